// File: doc/BRIEF.md
# Display Controller Power-On Reset Sequencer

This block brings a serially attached display controller out of power-up. Once `start` is pulsed it turns on the panel supply. In conditional mode it then asks the controller for its power-mode byte. If that byte shows that the display is already running, the block skips every reset step. This keeps an image that was set up earlier from flickering. Otherwise it pulses the controller's active-low reset pin, when the board has one, and waits for the controller to recover. It then sends the soft-reset command and waits the settling time that applies to the reset path just taken.

Commands reach a separate display-bus transmitter over a simple request/acknowledge port. `cmd_req` and `cmd_op` stay steady until the transmitter pulses `cmd_ack`. With the acknowledge the transmitter reports a failure (`cmd_fail`) and, for a read, whether a byte came back (`cmd_rvalid`, `cmd_rdata`). Every delay is a cycle count derived from `CLK_HZ`. `TIME_DIV` divides all delays, so a simulation can use short waits.

States and transitions:
- IDLE goes to PWR_UP on `start`.
- PWR_UP goes to:
  - PM_READ in conditional mode;
  - otherwise RST_LOW when a pin is present;
  - otherwise SOFT_RST.
- PM_READ, on acknowledge, goes to:
  - FINISH when the display is verified on;
  - otherwise RST_LOW or SOFT_RST, as from PWR_UP.
- RST_LOW goes to RST_REL when its timer expires.
- RST_REL goes to SOFT_RST when its timer expires.
- SOFT_RST, on acknowledge, goes to FINISH on failure, otherwise to SETTLE.
- SETTLE goes to FINISH when its timer expires.
- FINISH goes to IDLE.

Top module: `lcd_bringup_seq`

## Requirements
- R1: A `start` pulse is accepted only in IDLE; it is ignored in every other state, including the FINISH cycle. `supply_en` rises in the cycle after acceptance. The first command request or reset-pin change comes one cycle after `supply_en` rises.
- R2: In conditional mode (`cond_mode`=1, sampled at start) the first command is opcode 0x0A with `cmd_rd`=1. The reset pin does not move before that command is acknowledged.
- R3: The returned byte is first masked so that bits 0, 1 and 7 are ignored. If the masked byte equals 0x1C (bits 2, 3 and 4 set), the block skips the reset pin and the soft reset and sets `already_on`.
- R4: The full reset path follows the read in three cases: a read acknowledged with `cmd_fail`=1, a read acknowledged without `cmd_rvalid`, or a byte that does not match. In each case `already_on` stays 0.
- R5: With a reset pin present (`has_rst_pin`=1, sampled at start), `lcd_rst_n` is low for exactly T_LOW = max(1, CLK_HZ/10^6·20/TIME_DIV) cycles.
- R6: After the pin is released, the soft-reset request appears after exactly T_REL = max(1, CLK_HZ/10^6·120000/TIME_DIV) cycles of the pin being high.
- R7: The soft reset is opcode 0x01 with `cmd_rd`=0. It is issued exactly once per reset path. `cmd_req` and `cmd_op` hold until `cmd_ack`.
- R8: After a successful soft-reset acknowledge the block waits T_SHORT (5000 µs scaled) when a pin is present, or T_LONG (120000 µs scaled) when no pin is present. `done` is high T+1 cycles after the acknowledge cycle.
- R9: Without a reset pin, `lcd_rst_n` stays high for the whole sequence.
- R10: A soft-reset acknowledge with `cmd_fail`=1 clears `supply_en` and sets `error`, and `done` follows in the next cycle.
- R11: `done` is a single-cycle pulse. `already_on` and `error` hold until the next accepted start, which clears them. After reset all outputs are idle: `supply_en`=0 and `lcd_rst_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (pulse) |
| cond_mode | input | 1 | Check the power mode first (sampled at start) |
| has_rst_pin | input | 1 | Board has a controller reset pin (sampled at start) |
| supply_en | output | 1 | Panel supply enable |
| lcd_rst_n | output | 1 | Active-low controller reset pin |
| cmd_req | output | 1 | Command request to the bus transmitter |
| cmd_op | output | 8 | Command opcode |
| cmd_rd | output | 1 | Command expects one readback byte |
| cmd_ack | input | 1 | Transmitter finished the request (pulse) |
| cmd_fail | input | 1 | Transmitter reports a failure, valid with `cmd_ack` |
| cmd_rvalid | input | 1 | Readback byte present, valid with `cmd_ack` |
| cmd_rdata | input | 8 | Readback byte |
| done | output | 1 | Sequence finished (single-cycle pulse) |
| already_on | output | 1 | Display was found running and reset was skipped |
| error | output | 1 | Soft-reset command failed |

## Verification
The colliding pair is a new `start` and the completion pulse. A `start` presented in the same cycle as the FINISH cycle must not begin a new sequence and must not clear the result flags. The bench raises `start` exactly in the cycle where it observes `done`. It then watches for twenty cycles that no command request appears, that the reset pin stays high, and that `already_on`, `error` and `supply_en` keep their values. A second start in the middle of a long wait checks that a busy sequence ends with the same command count and timing it would have had without it.

// File: rtl/lcd_bringup_pkg.sv
package lcd_bringup_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PWR_UP,
        S_PM_READ,
        S_RST_LOW,
        S_RST_REL,
        S_SOFT_RST,
        S_SETTLE,
        S_FINISH
    } seq_state_t;

    // controller opcodes
    localparam logic [7:0] OP_PM_READ  = 8'h0A;
    localparam logic [7:0] OP_SOFT_RST = 8'h01;

    // power-mode byte: bits to disregard and the "running" pattern
    localparam logic [7:0] PM_DONT_CARE = 8'h83;
    localparam logic [7:0] PM_RUNNING   = 8'h1C;

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;
    logic         run_q;

    // a load of N makes 'expired' rise N cycles later (N >= 1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);

    // R5: a running count steps down by one each cycle until it ends
    p_tmr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (cnt_q != '0) && !load) |=> (run_q && (cnt_q == $past(cnt_q) - 1'b1)));

endmodule

// File: rtl/lcd_pwr_judge.sv
module lcd_pwr_judge
    import lcd_bringup_pkg::*;
(
    input  logic [7:0] pm_byte,
    input  logic       byte_ok,
    output logic       display_on
);

    logic [7:0] kept;

    assign kept       = pm_byte & ~PM_DONT_CARE;
    assign display_on = byte_ok && (kept == PM_RUNNING);

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
    import lcd_bringup_pkg::*;
#(
    parameter longint CLK_HZ          = 50_000_000,
    parameter longint TIME_DIV        = 1,
    parameter longint HOLD_LOW_US     = 20,
    parameter longint REL_WAIT_US     = 120_000,
    parameter longint SETTLE_PIN_US   = 5_000,
    parameter longint SETTLE_NOPIN_US = 120_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cond_mode,
    input  logic       has_rst_pin,
    output logic       supply_en,
    output logic       lcd_rst_n,
    output logic       cmd_req,
    output logic [7:0] cmd_op,
    output logic       cmd_rd,
    input  logic       cmd_ack,
    input  logic       cmd_fail,
    input  logic       cmd_rvalid,
    input  logic [7:0] cmd_rdata,
    output logic       done,
    output logic       already_on,
    output logic       error
);

    function automatic longint to_cyc(input longint us);
        longint v;
        v = (CLK_HZ / 1_000_000) * us / TIME_DIV;
        return (v < 1) ? 1 : v;
    endfunction

    localparam longint T_LOW   = to_cyc(HOLD_LOW_US);
    localparam longint T_REL   = to_cyc(REL_WAIT_US);
    localparam longint T_SHORT = to_cyc(SETTLE_PIN_US);
    localparam longint T_LONG  = to_cyc(SETTLE_NOPIN_US);
    localparam longint T_M1    = (T_LOW > T_REL) ? T_LOW : T_REL;
    localparam longint T_M2    = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
    localparam longint T_MAX   = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int     CNT_W   = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] V_LOW   = CNT_W'(T_LOW);
    localparam logic [CNT_W-1:0] V_REL   = CNT_W'(T_REL);
    localparam logic [CNT_W-1:0] V_SHORT = CNT_W'(T_SHORT);
    localparam logic [CNT_W-1:0] V_LONG  = CNT_W'(T_LONG);

    seq_state_t       state, nxt;
    logic             cond_q, pin_q, pwr_q, on_q, err_q;
    logic             tmr_load, tmr_exp, pm_on;
    logic [CNT_W-1:0] tmr_val;

    lcd_wait_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lcd_pwr_judge u_judge (
        .pm_byte    (cmd_rdata),
        .byte_ok    (cmd_rvalid && !cmd_fail),
        .display_on (pm_on)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE:   if (start) nxt = S_PWR_UP;
            S_PWR_UP: begin
                if (cond_q)     nxt = S_PM_READ;
                else if (pin_q) begin nxt = S_RST_LOW; tmr_load = 1'b1; tmr_val = V_LOW; end
                else            nxt = S_SOFT_RST;
            end
            S_PM_READ: if (cmd_ack) begin
                if (pm_on)      nxt = S_FINISH;
                else if (pin_q) begin nxt = S_RST_LOW; tmr_load = 1'b1; tmr_val = V_LOW; end
                else            nxt = S_SOFT_RST;
            end
            S_RST_LOW: if (tmr_exp) begin
                nxt = S_RST_REL; tmr_load = 1'b1; tmr_val = V_REL;
            end
            S_RST_REL: if (tmr_exp) nxt = S_SOFT_RST;
            S_SOFT_RST: if (cmd_ack) begin
                if (cmd_fail) nxt = S_FINISH;
                else begin
                    nxt = S_SETTLE; tmr_load = 1'b1;
                    tmr_val = pin_q ? V_SHORT : V_LONG;
                end
            end
            S_SETTLE: if (tmr_exp) nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // sampled configuration, supply and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            pin_q  <= 1'b0;
            pwr_q  <= 1'b0;
            on_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                cond_q <= cond_mode;
                pin_q  <= has_rst_pin;
                pwr_q  <= 1'b1;
                on_q   <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state == S_PM_READ && cmd_ack && pm_on) on_q <= 1'b1;
            if (state == S_SOFT_RST && cmd_ack && cmd_fail) begin
                err_q <= 1'b1;
                pwr_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        supply_en  = pwr_q;
        lcd_rst_n  = (state != S_RST_LOW);
        cmd_req    = (state == S_PM_READ) || (state == S_SOFT_RST);
        cmd_op     = (state == S_PM_READ) ? OP_PM_READ : OP_SOFT_RST;
        cmd_rd     = (state == S_PM_READ);
        done       = (state == S_FINISH);
        already_on = on_q;
        error      = err_q;
    end

    // R1: the reset pin is only driven while the supply is on
    p_rst_needs_supply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> supply_en);

    // R7: a pending request keeps its opcode until acknowledged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

    // R11: completion lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a failed soft reset switches the supply off
    p_fail_drops_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> !supply_en);

    // R3: a verified running display finishes at once, without any reset
    p_skip_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PM_READ && cmd_ack && pm_on) |=> (done && already_on && lcd_rst_n));

    // R9: without a pin the reset output never goes low
    p_no_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && !pin_q) |-> lcd_rst_n);

endmodule

// File: tb/sim_lcd_bringup_seq.sv
module sim_lcd_bringup_seq;

    localparam int CLK_HZ = 50_000_000;
    localparam int TDIV   = 1000;
    localparam int PER_US = CLK_HZ / 1_000_000;

    function automatic int scaled(input int us);
        int v;
        v = PER_US * us / TDIV;
        return (v < 1) ? 1 : v;
    endfunction

    logic       clk = 1'b0;
    logic       rst_n, start, cond_mode, has_rst_pin;
    logic       cmd_ack, cmd_fail, cmd_rvalid;
    logic [7:0] cmd_rdata;
    logic       supply_en, lcd_rst_n, cmd_req, cmd_rd, done, already_on, error;
    logic [7:0] cmd_op;

    int checks = 0;
    int errors = 0;
    int exp_low, exp_rel, exp_short, exp_long;

    always #10 clk = ~clk;

    lcd_bringup_seq #(.CLK_HZ(CLK_HZ), .TIME_DIV(TDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cond_mode(cond_mode),
        .has_rst_pin(has_rst_pin), .supply_en(supply_en), .lcd_rst_n(lcd_rst_n),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_ack(cmd_ack),
        .cmd_fail(cmd_fail), .cmd_rvalid(cmd_rvalid), .cmd_rdata(cmd_rdata),
        .done(done), .already_on(already_on), .error(error)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one full sequence; called and returns at a falling edge
    task automatic run_case(input bit cm, input bit pin, input logic [7:0] rb,
                            input bit rv, input bit rf, input bit sf,
                            input bit poke_busy, input bit poke_end);
        bit skip, seen_low, pending, ack_on, post_on, done_seen;
        int cyc, first_act, low_cnt, rel_cnt, n_rd, n_srst, lat, post_cnt;
        int first_op, first_rd, srst_rd, hold_err, post_at_done, rd_after_low;
        logic [7:0] hold_op;
        skip = cm && rv && !rf && ((rb & 8'h7C) == 8'h1C);
        seen_low = 0; pending = 0; ack_on = 0; post_on = 0; done_seen = 0;
        first_act = 0; low_cnt = 0; rel_cnt = 0; n_rd = 0; n_srst = 0; lat = 0;
        post_cnt = 0; first_op = -1; first_rd = -1; srst_rd = -1; hold_err = 0;
        post_at_done = -1; rd_after_low = 0; hold_op = 8'h00;

        cond_mode = cm; has_rst_pin = pin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk("R1 supply on after start", int'(supply_en), 1);
        chk("R11 already_on cleared by start", int'(already_on), 0);
        chk("R11 error cleared by start", int'(error), 0);

        while (!done_seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke_busy && cyc == 20) start = 1'b1;
            if (poke_busy && cyc == 21) start = 1'b0;
            if (post_on) post_cnt++;
            if (ack_on) begin
                cmd_ack = 0; cmd_fail = 0; cmd_rvalid = 0;
                ack_on = 0; pending = 0;
            end
            if (done) begin
                done_seen = 1;
                post_at_done = post_cnt;
            end else begin
                if (!lcd_rst_n) begin
                    low_cnt++; seen_low = 1;
                    if (first_act == 0) first_act = cyc;
                end
                if (seen_low && lcd_rst_n && n_srst == 0 && !cmd_req) rel_cnt++;
                if (cmd_req && !pending) begin
                    pending = 1; lat = 2; hold_op = cmd_op;
                    if (first_act == 0) first_act = cyc;
                    if (first_op < 0) begin first_op = cmd_op; first_rd = cmd_rd; end
                    if (cmd_op == 8'h0A) begin n_rd++; if (seen_low) rd_after_low++; end
                    if (cmd_op == 8'h01) begin n_srst++; srst_rd = cmd_rd; end
                end else if (pending) begin
                    if (!cmd_req || cmd_op != hold_op) hold_err++;
                    lat--;
                    if (lat == 0) begin
                        cmd_ack = 1; ack_on = 1;
                        if (hold_op == 8'h0A) begin
                            cmd_fail = rf; cmd_rvalid = rv; cmd_rdata = rb;
                        end else begin
                            cmd_fail = sf; cmd_rvalid = 0; cmd_rdata = 8'h00;
                            post_on = 1; post_cnt = 0;
                        end
                    end
                end
            end
        end

        chk("R11 done observed", int'(done_seen), 1);
        chk("R1 first action one cycle after supply", first_act, 2);
        if (cm) begin
            chk("R2 first opcode is power-mode read", first_op, 8'h0A);
            chk("R2 read flag set", first_rd, 1);
            chk("R2 no reset before read", rd_after_low, 0);
        end
        if (skip) begin
            chk("R3 no soft reset when on", n_srst, 0);
            chk("R3 no pin pulse when on", low_cnt, 0);
            chk("R3 already_on set", int'(already_on), 1);
        end else begin
            chk("R4 already_on clear", int'(already_on), 0);
            chk("R7 single soft reset", n_srst, 1);
            chk("R7 soft reset read flag", srst_rd, 0);
            chk("R7 request held until ack", hold_err, 0);
            if (pin) begin
                chk("R5 reset low width", low_cnt, exp_low);
                chk("R6 release wait", rel_cnt, exp_rel);
            end else begin
                chk("R9 pin never low", low_cnt, 0);
            end
            if (sf) begin
                chk("R10 error set", int'(error), 1);
                chk("R10 supply off", int'(supply_en), 0);
                chk("R10 done right after fail", post_at_done, 1);
            end else begin
                chk("R10 no error", int'(error), 0);
                chk("R8 supply stays on", int'(supply_en), 1);
                chk("R8 settle length", post_at_done, (pin ? exp_short : exp_long) + 1);
            end
        end

        start = poke_end;
        @(negedge clk);
        start = 1'b0;
        chk("R11 done single cycle", int'(done), 0);
        chk("R11 already_on held", int'(already_on), int'(skip));
        chk("R11 error held", int'(error), int'(!skip && sf));
        if (poke_end) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (cmd_req || !lcd_rst_n || done) begin
                    chk("R1 start in finish cycle ignored", 1, 0);
                    break;
                end
            end
            chk("R1 flags kept after ignored start", int'(already_on), int'(skip));
            chk("R1 supply kept after ignored start", int'(supply_en), int'(skip || !sf));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_low   = scaled(20);
        exp_rel   = scaled(120000);
        exp_short = scaled(5000);
        exp_long  = scaled(120000);
        rst_n = 0; start = 0; cond_mode = 0; has_rst_pin = 0;
        cmd_ack = 0; cmd_fail = 0; cmd_rvalid = 0; cmd_rdata = 8'h00;
        repeat (3) @(negedge clk);
        chk("R11 reset supply off", int'(supply_en), 0);
        chk("R11 reset pin high", int'(lcd_rst_n), 1);
        chk("R11 reset no request", int'(cmd_req), 0);
        chk("R11 reset no done", int'(done), 0);
        rst_n = 1;
        @(negedge clk);

        // direct reset paths
        run_case(0, 1, 8'h00, 0, 0, 0, 0, 1);
        run_case(0, 0, 8'h00, 0, 0, 0, 0, 0);
        run_case(0, 1, 8'h00, 0, 0, 1, 0, 0);
        run_case(0, 0, 8'h00, 0, 0, 1, 0, 0);
        // conditional mode outcomes
        run_case(1, 1, 8'h1C, 1, 0, 0, 0, 1);
        run_case(1, 1, 8'h9F, 1, 0, 0, 0, 0);
        run_case(1, 1, 8'h14, 1, 0, 0, 1, 0);
        run_case(1, 0, 8'h3C, 1, 0, 0, 0, 0);
        run_case(1, 1, 8'h1C, 1, 1, 0, 0, 0);
        run_case(1, 0, 8'h1C, 0, 0, 0, 0, 0);
        // every power-mode byte, short path (failing soft reset, no pin)
        for (int b = 0; b < 256; b++) run_case(1, 0, 8'(b), 1, 0, 1, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule